// File: doc/BRIEF.md
# Indexed-Source DMA Channel with Ping-Pong Block Signalling

This block is one DMA channel. It copies frames of 64-bit elements from a small register window in a peripheral into a linear RAM buffer. Each pulse on the hardware request input moves exactly one frame. Each element in that frame takes two bus transfers: a read from the source address, then a write of the same data to the destination address.

The destination address walks forward one element at a time. The source address follows two signed steps. The element step is added after every element except the last one in a frame. The frame step is added after the last element. With a frame step equal to minus the element step times (elements per frame minus one), every frame reads the same register window again.

The channel pulses a half-block interrupt when the middle frame of the block lands, and a block-complete interrupt when the final frame lands. With auto-init on, the channel reloads its start addresses and frame count at block end and keeps running, so software can drain one half of the buffer while the other half fills. With auto-init off, the channel turns itself off at block end.

Top module: `idx_dma_chan`

## Requirements
- R1: While reset is held low and on the first cycle after it is released, `chan_en`, `bus_req`, `irq_half` and `irq_done` are all 0.
- R2: A request on an enabled, idle channel starts one frame. A frame is `ELEMS_PER_FRAME` elements (default 2). Each element is one read beat (`bus_we`=0) followed by one write beat (`bus_we`=1). A beat holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until the cycle in which `bus_ack` is high.
- R3: The write address of element e in frame k of a block is `cfg_dst_start + 8*(k*ELEMS_PER_FRAME + e)`, modulo 2^32.
- R4: The read address of element e in frame k of a block is `cfg_src_start + k*(cfg_elem_idx*(ELEMS_PER_FRAME-1) + cfg_frame_idx) + e*cfg_elem_idx`. Both steps are two's-complement values, and the sum wraps at 32 bits.
- R5: Each write beat carries the data that was returned by the read beat just before it.
- R6: `irq_half` is high for exactly one cycle. That cycle is the one after the write acknowledge that completes frame number FRAMES_PER_BLOCK/2 of the block (default 32).
- R7: `irq_done` is high for exactly one cycle. That cycle is the one after the write acknowledge that completes the last frame of the block (default 64).
- R8: If `cfg_auto_init` is 1 at block end, the channel stays enabled. It restarts at `cfg_src_start` and `cfg_dst_start` with a frame count of zero, and the next request fills the first half of the buffer again.
- R9: If `cfg_auto_init` is 0 at block end, `chan_en` drops. After that, requests cause no bus activity until `cfg_enable_set` is pulsed again.
- R10: Requests that arrive while a frame is in progress are collapsed into one pending request. Exactly one more frame runs after the current one, however many requests arrived.
- R11: A `cfg_enable_set` pulse loads the start addresses and clears the frame count only when `chan_en` is 0. While the channel is enabled, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable_set | input | 1 | Pulse: enable the channel and load the start configuration |
| cfg_auto_init | input | 1 | Reload and continue at block end |
| cfg_src_start | input | 32 | Source window start address |
| cfg_dst_start | input | 32 | Destination buffer start address |
| cfg_elem_idx | input | 32 | Signed source step added after each non-final element |
| cfg_frame_idx | input | 32 | Signed source step added after the final element of a frame |
| hw_req | input | 1 | Peripheral request; one frame per request |
| bus_req | output | 1 | Bus beat requested |
| bus_we | output | 1 | 1 = write beat, 0 = read beat |
| bus_addr | output | 32 | Beat address |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` on a read beat |
| bus_ack | input | 1 | Beat accepted this cycle |
| chan_en | output | 1 | Channel enabled |
| irq_half | output | 1 | Half-block pulse |
| irq_done | output | 1 | Block-complete pulse |

## Verification
The assertions are checked on every clock cycle. They cover:
- an unacknowledged beat holding its address, direction and data;
- the two interrupts never firing together;
- the frame counter staying inside the block;
- a disabled channel staying off the bus;
- the destination moving by one element on each write acknowledge.

Other behaviours need whole scenarios from the bench:
- the signed source walk across frames and past the 32-bit wrap;
- reads and writes pairing up;
- auto-init restarting the buffer at its first half;
- several requests collapsing into one pending frame;
- an enable pulse being ignored mid-block.

// File: rtl/idma_pkg.sv
// Shared types for the indexed DMA channel.
// Assumes: a single channel; no arbitration sits inside this block.
package idma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/dma_addr_unit.sv
// Source and destination address registers for one channel.
// The source steps by a signed element index or by a signed frame index.
// The destination steps by one element. All sums wrap at AW bits.
// Assumes: load has priority over step; step is a write acknowledge.
module dma_addr_unit #(
    parameter int AW         = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          last_elem,
    input  logic [AW-1:0] src_start,
    input  logic [AW-1:0] dst_start,
    input  logic [AW-1:0] elem_idx,
    input  logic [AW-1:0] frame_idx,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr
);
    localparam logic [AW-1:0] DST_STEP = AW'(ELEM_BYTES);

    logic [AW-1:0] src_q, dst_q;

    // Load start addresses, or advance both addresses after a write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (load) begin
            src_q <= src_start;
            dst_q <= dst_start;
        end else if (step) begin
            src_q <= src_q + (last_elem ? frame_idx : elem_idx);
            dst_q <= dst_q + DST_STEP;
        end
    end

    assign src_addr = src_q;
    assign dst_addr = dst_q;

    // R3
    dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (dst_q == $past(dst_q) + DST_STEP));
endmodule

// File: rtl/dma_seq_ctrl.sv
// Frame sequencer. It handles enable, pending requests, the read/write beat
// order, element and frame counting, interrupts and auto-init reload.
// Assumes: hw_req is sampled every cycle; the bus holds a beat until bus_ack.
module dma_seq_ctrl
    import idma_pkg::*;
#(
    parameter int ELEMS  = 2,
    parameter int FRAMES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_set,
    input  logic       auto_init,
    input  logic       hw_req,
    input  logic       bus_ack,
    output seq_state_t state,
    output logic       step,
    output logic       last_elem,
    output logic       load,
    output logic       chan_en,
    output logic       irq_half,
    output logic       irq_done
);
    localparam int EW   = (ELEMS > 1) ? $clog2(ELEMS) : 1;
    localparam int FW   = $clog2(FRAMES + 1);
    localparam int HALF = FRAMES / 2;

    seq_state_t    state_q, state_d;
    logic [EW-1:0] elem_q;
    logic [FW-1:0] frame_q, frame_nxt;
    logic          chan_en_q, pend_q;
    logic          irq_half_q, irq_done_q;
    logic          frame_end, block_end, en_take, keep_on;

    assign step      = (state_q == ST_WR) && bus_ack;
    assign last_elem = (elem_q == EW'(ELEMS - 1));
    assign frame_end = step && last_elem;
    assign frame_nxt = frame_q + 1'b1;
    assign block_end = frame_end && (frame_nxt == FW'(FRAMES));
    assign en_take   = en_set && !chan_en_q;
    assign load      = en_take || (block_end && auto_init);
    assign keep_on   = chan_en_q && !(block_end && !auto_init);

    // Next beat: start a frame from idle, alternate read and write, chain a pending frame.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (chan_en_q && (hw_req || pend_q)) state_d = ST_RD;
            ST_RD:   if (bus_ack) state_d = ST_WR;
            ST_WR: begin
                if (bus_ack) begin
                    if (!last_elem)                      state_d = ST_RD;
                    else if (keep_on && (hw_req || pend_q)) state_d = ST_RD;
                    else                                 state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, counters, enable and the pending-request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            elem_q    <= '0;
            frame_q   <= '0;
            chan_en_q <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (en_take) begin
                chan_en_q <= 1'b1;
                frame_q   <= '0;
                elem_q    <= '0;
            end else begin
                if (block_end && !auto_init) chan_en_q <= 1'b0;
                if (step) elem_q <= last_elem ? '0 : elem_q + 1'b1;
                if (frame_end) frame_q <= block_end ? '0 : frame_nxt;
            end
            if (!keep_on || state_q == ST_IDLE || frame_end) pend_q <= 1'b0;
            else if (hw_req)                                    pend_q <= 1'b1;
        end
    end

    // One-cycle interrupt pulses registered from the frame-completion event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_half_q <= 1'b0;
            irq_done_q <= 1'b0;
        end else begin
            irq_half_q <= frame_end && (frame_nxt == FW'(HALF));
            irq_done_q <= block_end;
        end
    end

    assign state    = state_q;
    assign chan_en  = chan_en_q;
    assign irq_half = irq_half_q;
    assign irq_done = irq_done_q;

    // R9
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en_q |-> (state_q == ST_IDLE));
    // R6 R7
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_half_q, irq_done_q}));
    // R7
    frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_q < FW'(FRAMES));
    // R8
    done_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done_q |-> (frame_q == '0));
endmodule

// File: rtl/idx_dma_chan.sv
// Top of one indexed-source DMA channel. It joins the sequencer and the
// address unit, latches read data for the write beat and drives the bus port.
// Assumes: the peripheral window is readable at the indexed addresses and the
// bus returns read data in the cycle bus_ack is high.
module idx_dma_chan
    import idma_pkg::*;
#(
    parameter int ADDR_W           = 32,
    parameter int DATA_W           = 64,
    parameter int ELEMS_PER_FRAME  = 2,
    parameter int FRAMES_PER_BLOCK = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable_set,
    input  logic              cfg_auto_init,
    input  logic [ADDR_W-1:0] cfg_src_start,
    input  logic [ADDR_W-1:0] cfg_dst_start,
    input  logic [ADDR_W-1:0] cfg_elem_idx,
    input  logic [ADDR_W-1:0] cfg_frame_idx,
    input  logic              hw_req,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    output logic              chan_en,
    output logic              irq_half,
    output logic              irq_done
);
    localparam int ELEM_BYTES = DATA_W / 8;

    seq_state_t        state;
    logic              step, last_elem, load;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    logic [DATA_W-1:0] rd_buf;

    dma_seq_ctrl #(
        .ELEMS  (ELEMS_PER_FRAME),
        .FRAMES (FRAMES_PER_BLOCK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set    (cfg_enable_set),
        .auto_init (cfg_auto_init),
        .hw_req    (hw_req),
        .bus_ack   (bus_ack),
        .state     (state),
        .step      (step),
        .last_elem (last_elem),
        .load      (load),
        .chan_en   (chan_en),
        .irq_half  (irq_half),
        .irq_done  (irq_done)
    );

    dma_addr_unit #(
        .AW         (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .last_elem (last_elem),
        .src_start (cfg_src_start),
        .dst_start (cfg_dst_start),
        .elem_idx  (cfg_elem_idx),
        .frame_idx (cfg_frame_idx),
        .src_addr  (src_addr),
        .dst_addr  (dst_addr)
    );

    // Hold the element returned by the read beat for the write beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_buf <= '0;
        else if (state == ST_RD && bus_ack) rd_buf <= bus_rdata;
    end

    assign bus_req   = (state != ST_IDLE);
    assign bus_we    = (state == ST_WR);
    assign bus_addr  = bus_we ? dst_addr : src_addr;
    assign bus_wdata = rd_buf;

    // R2
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)
                                   && $stable(bus_wdata)));
endmodule

// File: tb/sim_idx_dma_chan.sv
module sim_idx_dma_chan;
    localparam int EL = 2;
    localparam int FR = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable_set = 1'b0;
    logic        cfg_auto_init = 1'b0;
    logic [31:0] cfg_src_start = '0, cfg_dst_start = '0;
    logic [31:0] cfg_elem_idx = '0, cfg_frame_idx = '0;
    logic        hw_req = 1'b0;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [31:0] bus_addr;
    logic [63:0] bus_wdata, bus_rdata = '0;
    logic        chan_en, irq_half, irq_done;

    int total = 0, fails = 0;
    int frames_done = 0, beat = 0, half_cnt = 0, done_cnt = 0;
    logic [31:0] rd_cnt = '0;
    logic [63:0] last_rd = '0;

    idx_dma_chan u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] src_exp(int f, int e);
        logic [31:0] per;
        per = cfg_elem_idx * 32'(EL - 1) + cfg_frame_idx;
        return cfg_src_start + 32'(f % FR) * per + 32'(e) * cfg_elem_idx;
    endfunction

    function automatic logic [31:0] dst_exp(int f, int e);
        return cfg_dst_start + 32'((((f % FR) * EL) + e) * 8);
    endfunction

    // Bus responder and interrupt monitor, both on the falling edge.
    always @(negedge clk) begin
        if (irq_half) begin
            half_cnt++;
            chk(frames_done % FR == FR / 2, "R6 half frame", 64'(frames_done), 64'(FR / 2));
        end
        if (irq_done) begin
            done_cnt++;
            chk(frames_done % FR == 0 && frames_done > 0, "R7 done frame", 64'(frames_done), 64'(FR));
        end
        if (bus_ack) begin
            bus_ack = 1'b0;
        end else if (rst_n && bus_req && ($urandom % 4 != 0)) begin
            chk(bus_we == beat[0], "R2 beat order", 64'(bus_we), 64'(beat[0]));
            if (!beat[0]) begin
                chk(bus_addr == src_exp(frames_done, beat / 2), "R4 src addr",
                    64'(bus_addr), 64'(src_exp(frames_done, beat / 2)));
                bus_rdata = {bus_addr, rd_cnt};
                last_rd = bus_rdata;
                rd_cnt++;
            end else begin
                chk(bus_addr == dst_exp(frames_done, beat / 2), "R3 R8 dst addr",
                    64'(bus_addr), 64'(dst_exp(frames_done, beat / 2)));
                chk(bus_wdata == last_rd, "R5 write data", bus_wdata, last_rd);
            end
            beat++;
            if (beat == 2 * EL) begin
                beat = 0;
                frames_done++;
            end
            bus_ack = 1'b1;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (bus_req) @(negedge clk);
    endtask

    task automatic req_n(int n);
        @(negedge clk) hw_req = 1'b1;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk) hw_req = 1'b0;
        wait_idle();
    endtask

    task automatic pulse_en();
        @(negedge clk) cfg_enable_set = 1'b1;
        @(negedge clk) cfg_enable_set = 1'b0;
    endtask

    task automatic phase_start();
        frames_done = 0; beat = 0; half_cnt = 0; done_cnt = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!chan_en && !bus_req && !irq_half && !irq_done, "R1 in reset",
            {chan_en, bus_req, irq_half, irq_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!chan_en && !bus_req && !irq_half && !irq_done, "R1 after reset",
            {chan_en, bus_req, irq_half, irq_done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int fd, bb;
        bit en_poked;
        void'($urandom(32'd1234));
        do_reset();

        // Phase 1: single block, no auto-init (R6, R7, R9)
        cfg_src_start = 32'h4000_0100; cfg_dst_start = 32'h2000_0000;
        cfg_elem_idx = 32'd8; cfg_frame_idx = -32'sd8; cfg_auto_init = 1'b0;
        phase_start();
        pulse_en();
        chk(chan_en, "R11 enable taken", 64'(chan_en), 1);
        for (int i = 0; i < FR; i++) begin
            req_n(1);
            repeat ($urandom % 3) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(frames_done == FR, "R2 one frame per request", 64'(frames_done), 64'(FR));
        chk(half_cnt == 1 && done_cnt == 1, "R6 R7 pulse counts", 64'({half_cnt[15:0], done_cnt[15:0]}), 64'h0001_0001);
        chk(!chan_en, "R9 disabled at block end", 64'(chan_en), 0);
        fd = frames_done;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk) hw_req = 1'b1;
            @(negedge clk) hw_req = 1'b0;
        end
        repeat (20) @(negedge clk);
        chk(frames_done == fd && beat == 0 && !bus_req, "R9 requests ignored", 64'(frames_done), 64'(fd));

        // Phase 2: auto-init ping-pong, source wrap, pending requests (R8, R10, R11)
        cfg_src_start = 32'hFFFF_FFF8; cfg_dst_start = 32'h8000_0000;
        cfg_elem_idx = 32'd8; cfg_frame_idx = -32'sd8; cfg_auto_init = 1'b1;
        phase_start();
        pulse_en();
        en_poked = 1'b0;
        while (frames_done < 150) begin
            if (!en_poked && frames_done >= 10) begin
                // R11: pulse while enabled; later address checks expose any reload
                pulse_en();
                en_poked = 1'b1;
            end
            if ($urandom % 3 == 0 && frames_done < 148) begin
                bb = frames_done;
                req_n(4);
                chk(frames_done - bb == 2, "R10 collapsed pending", 64'(frames_done - bb), 2);
            end else begin
                req_n(1);
            end
        end
        repeat (2) @(negedge clk);
        chk(chan_en, "R8 stays enabled", 64'(chan_en), 1);
        chk(half_cnt == 2 && done_cnt == 2, "R8 two blocks signalled",
            64'({half_cnt[15:0], done_cnt[15:0]}), 64'h0002_0002);

        // Phase 3: negative element step, drifting frame step, wrapping destination (R4)
        do_reset();
        cfg_src_start = 32'h1000_0000; cfg_dst_start = 32'hFFFF_FF00;
        cfg_elem_idx = -32'sd8; cfg_frame_idx = 32'd16; cfg_auto_init = 1'b0;
        phase_start();
        pulse_en();
        for (int i = 0; i < 40; i++) req_n(1);
        repeat (2) @(negedge clk);
        chk(frames_done == 40 && half_cnt == 1 && done_cnt == 0, "R4 R6 signed walk",
            64'(frames_done), 40);
        chk(chan_en, "R9 enabled mid-block", 64'(chan_en), 1);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule